// File: doc/BRIEF.md
# Dual Countdown Timer

This block puts two independent down-counting timers behind one word-addressed register window. Software selects a timer by address: timer 0 owns window words 0 to 7, timer 1 owns words 8 to 15, and anything above that is unmapped. Each timer holds a live count, a load value, a background load value, a three-bit control word and a raw interrupt flag. A masked view of that flag is also readable. Each timer drives its own interrupt line.

A timer only advances when the shared `tick` enable is high at a clock edge. When a timer is running and its count is already 0 on a tick, the timer expires. In periodic mode it reloads from the load value and keeps going, so one period is load+1 ticks. In one-shot mode it stops at 0. The background load register changes the next reload value without disturbing the count in flight. Writes take effect at the clock edge. Reads are combinational from the address. No data stream crosses the block's edge, so the bus and interrupt pins are plain signals with no handshake.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset every readable word of both timers reads 0, both timers are stopped and both `irq` bits are low.
- R2: Writing control (offset 3) with bit 0 (enable) set copies the load value into the count and starts the timer. Writing control with bit 0 clear stops it, and the count then holds on later ticks.
- R3: A running timer decrements its count by one on each tick. A tick while the count is 0 is the expiry event, and it sets raw status (offset 4) bit 0.
- R4: In periodic mode (control bit 1 clear), expiry reloads the count from the load value and the timer keeps running, so expiries are load+1 ticks apart.
- R5: In one-shot mode (control bit 1 set), expiry stops the timer with the count left at 0. Further ticks neither change the count nor set raw status again.
- R6: Writing raw status with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged. If an expiry and a clearing write fall on the same edge, the flag ends up set.
- R7: Masked status (offset 5) reads raw bit 0 AND control bit 2 (interrupt enable) in bit 0, and that timer's `irq` bit equals the same value.
- R8: Writing the load value (offset 1) while control bit 0 is set reloads the count at once and restarts the timer. While control bit 0 is clear, the write only stores the value.
- R9: Writing background load (offset 2) sets both the background load and the load value and leaves the running count unchanged. The new value is used at the next reload.
- R10: Writes to the count (offset 0) and masked status (offset 5) are ignored. Reading offset 0 returns the live count.
- R11: Timer k answers at words 8k+0 to 8k+7. Offsets 6 and 7 read 0 and ignore writes. Addresses 16 and above read 0 and drop writes.
- R12: Control reads back only bits 2:0 as written. All higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable shared by both timers |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 2 | Per-timer interrupt, bit k for timer k |

## Verification
The bench builds the block with its defaults: two timers, eight-word windows and a five-bit address. With these values every one of the 32 addresses, including the whole unmapped upper half, can be swept on reads and writes. Load values from 0 to 5 are swept on both timers, so each period length can be counted tick by tick against load+1. The same-edge expiry-versus-clear race and the background reload are driven explicitly.

// File: rtl/dct_pkg.sv
package dct_pkg;
  // Word offsets inside one timer window
  localparam int OFS_COUNT  = 0;
  localparam int OFS_LOAD   = 1;
  localparam int OFS_BGLOAD = 2;
  localparam int OFS_CTRL   = 3;
  localparam int OFS_RAW    = 4;
  localparam int OFS_MASKED = 5;
  // Control word bit positions
  localparam int CTL_EN      = 0;
  localparam int CTL_ONESHOT = 1;
  localparam int CTL_IE      = 2;
  localparam int CTL_W       = 3;
endpackage

// File: rtl/dct_addr_decode.sv
module dct_addr_decode #(
  parameter int ADDR_W    = 5,
  parameter int WIN_WORDS = 8,
  parameter int NUM_TMR   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  output logic [NUM_TMR-1:0]            sel,
  output logic [$clog2(WIN_WORDS)-1:0]  ofs
);
  localparam int OFS_W = $clog2(WIN_WORDS);
  localparam int IDX_W = ADDR_W - OFS_W;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_TMR * WIN_WORDS);

  logic [IDX_W-1:0] idx;
  logic             in_range;

  assign idx      = addr[ADDR_W-1:OFS_W];
  assign ofs      = addr[OFS_W-1:0];
  assign in_range = ({1'b0, addr} < LIMIT);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_sel
    assign sel[i] = in_range && (idx == IDX_W'(i));
  end

  // At most one timer is ever addressed
  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  // Unmapped addresses select nothing
  assert_oob_nosel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, addr} >= LIMIT) |-> (sel == '0));
endmodule

// File: rtl/dct_timer_core.sv
module dct_timer_core
  import dct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] count_q, load_q, bg_q;
  logic [CTL_W-1:0]  ctrl_q;
  logic              running_q, ris_q;
  logic              wr_ctrl, wr_load, wr_bg, wr_raw, expire;

  assign wr_ctrl = wr_en && (ofs == OFS_W'(OFS_CTRL));
  assign wr_load = wr_en && (ofs == OFS_W'(OFS_LOAD));
  assign wr_bg   = wr_en && (ofs == OFS_W'(OFS_BGLOAD));
  assign wr_raw  = wr_en && (ofs == OFS_W'(OFS_RAW));
  assign expire  = tick && running_q && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      load_q    <= '0;
      bg_q      <= '0;
      ctrl_q    <= '0;
      running_q <= 1'b0;
      ris_q     <= 1'b0;
    end else begin
      // counting path
      if (expire) begin
        ris_q <= 1'b1;
        if (ctrl_q[CTL_ONESHOT]) running_q <= 1'b0;
        else                     count_q   <= load_q;
      end else if (tick && running_q) begin
        count_q <= count_q - 1'b1;
      end
      // register writes override the counting path
      if (wr_ctrl) begin
        ctrl_q <= wdata[CTL_W-1:0];
        if (wdata[CTL_EN]) begin
          count_q   <= load_q;
          running_q <= 1'b1;
        end else begin
          running_q <= 1'b0;
        end
      end
      if (wr_load) begin
        load_q <= wdata;
        if (ctrl_q[CTL_EN]) begin
          count_q   <= wdata;
          running_q <= 1'b1;
        end
      end
      if (wr_bg) begin
        bg_q   <= wdata;
        load_q <= wdata;
      end
      if (wr_raw && wdata[0] && !expire) ris_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (ofs)
      OFS_W'(OFS_COUNT):  rdata = count_q;
      OFS_W'(OFS_LOAD):   rdata = load_q;
      OFS_W'(OFS_BGLOAD): rdata = bg_q;
      OFS_W'(OFS_CTRL):   rdata = DATA_W'(ctrl_q);
      OFS_W'(OFS_RAW):    rdata = DATA_W'(ris_q);
      OFS_W'(OFS_MASKED): rdata = DATA_W'(ris_q & ctrl_q[CTL_IE]);
      default:            rdata = '0;
    endcase
  end

  assign irq = ris_q & ctrl_q[CTL_IE];

  assert_expiry_sets_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ris_q);
  assert_oneshot_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q[CTL_ONESHOT] && !wr_ctrl && !wr_load) |=> (!running_q && count_q == '0));
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_raw && wdata[0] && !expire) |=> !ris_q);
  assert_bg_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bg && !tick) |=> $stable(count_q));
  assert_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !wr_ctrl && !wr_load) |=> $stable(count_q));
  assert_irq_needs_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTL_IE] |-> !irq);
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int WIN_WORDS = 8,
  parameter int NUM_TMR   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_TMR-1:0] irq
);
  localparam int OFS_W = $clog2(WIN_WORDS);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_TMR * WIN_WORDS);

  logic [NUM_TMR-1:0] sel;
  logic [OFS_W-1:0]   ofs;
  logic [DATA_W-1:0]  core_rd [NUM_TMR];

  dct_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_WORDS(WIN_WORDS), .NUM_TMR(NUM_TMR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .sel(sel), .ofs(ofs)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dct_timer_core #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .wr_en(bus_wr && sel[i]), .ofs(ofs), .wdata(bus_wdata),
      .rdata(core_rd[i]), .irq(irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (sel[i]) bus_rdata = core_rd[i];
    end
  end

  assert_oob_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, bus_addr} >= LIMIT) |-> (bus_rdata == '0));
endmodule

// File: tb/dual_countdown_timer_tb.sv
`timescale 1ns/1ps
module dual_countdown_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_countdown_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_rd(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, full address sweep
    for (int a = 0; a < 32; a++) chk_rd("R1 reset read", a, 0);
    chk("R1 irq reset", 32'(irq), 0);
    // R10 / R11: writes to ignored offsets and unmapped space
    for (int t = 0; t < 2; t++) begin
      wr(t*8 + 0, 32'hFFFF_FFFF);
      wr(t*8 + 5, 32'hFFFF_FFFF);
      wr(t*8 + 6, 32'hFFFF_FFFF);
      wr(t*8 + 7, 32'hFFFF_FFFF);
    end
    for (int a = 16; a < 32; a++) wr(a, 32'hFFFF_FFFF);
    for (int a = 0; a < 32; a++) chk_rd("R10 R11 ignored writes", a, 0);

    // Periodic sweep over load values on both timers
    for (int t = 0; t < 2; t++) begin
      for (int L = 0; L < 6; L++) begin
        int b;
        b = t*8;
        wr(b + 1, L);
        wr(b + 3, 32'h5);
        chk_rd("R2 enable loads count", b + 0, L);
        ticks(L);
        chk_rd("R3 count at zero", b + 0, 0);
        chk_rd("R3 no early expiry", b + 4, 0);
        ticks(1);
        chk_rd("R3 expiry sets raw", b + 4, 1);
        chk_rd("R7 masked status", b + 5, 1);
        chk("R7 irq own", 32'(irq[t]), 1);
        chk("R7 irq other", 32'(irq[1-t]), 0);
        chk_rd("R4 periodic reload", b + 0, L);
        wr(b + 4, 0);
        chk_rd("R6 write zero keeps raw", b + 4, 1);
        wr(b + 4, 1);
        chk_rd("R6 w1c clears raw", b + 4, 0);
        chk("R6 irq drops", 32'(irq[t]), 0);
        ticks(L + 1);
        chk_rd("R4 second period", b + 4, 1);
        wr(b + 4, 1);
        wr(b + 3, 0);
        ticks(2);
        chk_rd("R2 stopped count holds", b + 0, L);
        chk_rd("R2 stopped no expiry", b + 4, 0);
      end
    end

    for (int t = 0; t < 2; t++) begin
      int b;
      b = t*8;
      // R5: one-shot with load 3
      wr(b + 1, 3);
      wr(b + 3, 32'h3);
      ticks(4);
      chk_rd("R5 oneshot expiry", b + 4, 1);
      chk_rd("R5 oneshot count zero", b + 0, 0);
      chk_rd("R7 masked off without ie", b + 5, 0);
      chk("R7 irq off without ie", 32'(irq[t]), 0);
      // R12: control keeps only low bits; ie only (disables)
      wr(b + 3, 32'hFFFF_FFF4);
      chk_rd("R12 control readback", b + 3, 4);
      chk_rd("R7 masked with ie", b + 5, 1);
      chk("R7 irq with ie", 32'(irq[t]), 1);
      wr(b + 4, 1);
      wr(b + 3, 32'h3);
      ticks(4);
      wr(b + 4, 1);
      ticks(3);
      chk_rd("R5 no re-expiry", b + 4, 0);
      chk_rd("R5 count stays zero", b + 0, 0);

      // R8: load write while enabled restarts
      wr(b + 3, 0);
      wr(b + 1, 10);
      wr(b + 3, 32'h1);
      ticks(3);
      chk_rd("R3 decrement", b + 0, 7);
      wr(b + 1, 4);
      chk_rd("R8 live reload", b + 0, 4);
      wr(b + 3, 0);
      wr(b + 1, 9);
      chk_rd("R8 disabled load stores only", b + 0, 4);
      chk_rd("R8 load value stored", b + 1, 9);

      // R9: background load
      wr(b + 1, 10);
      wr(b + 3, 32'h1);
      ticks(2);
      wr(b + 2, 3);
      chk_rd("R9 count undisturbed", b + 0, 8);
      chk_rd("R9 load updated", b + 1, 3);
      chk_rd("R9 bg updated", b + 2, 3);
      ticks(8);
      chk_rd("R9 no early expiry", b + 4, 0);
      ticks(1);
      chk_rd("R9 reload uses new value", b + 0, 3);
      chk_rd("R9 expiry", b + 4, 1);

      // R10: write to count offset ignored while running
      wr(b + 0, 32'h55);
      chk_rd("R10 count write ignored", b + 0, 3);

      // R6: same-edge expiry and clear, flag stays set
      wr(b + 4, 1);
      ticks(3);
      chk_rd("R6 count at zero before race", b + 0, 0);
      @(negedge clk);
      tick = 1'b1; bus_wr = 1'b1; bus_addr = 5'(b + 4); bus_wdata = 1;
      @(negedge clk);
      tick = 1'b0; bus_wr = 1'b0;
      chk_rd("R6 expiry beats clear", b + 4, 1);
      wr(b + 3, 0);
      wr(b + 4, 1);
    end

    // R11: unmapped reads stay zero with live state present
    for (int a = 16; a < 32; a++) chk_rd("R11 unmapped read", a, 0);
    chk_rd("R11 timer1 offset 6", 14, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule